// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Core

This block keeps wall-clock time and date in packed BCD: seconds, minutes, 24-hour hours, a day-of-week count, day of month, month and a two-digit year. A free-running prescaler counts single-cycle timebase enables, nominally 32.768 kHz, and produces one seconds tick per 2^PRESC_W enables. Months have their true lengths. February gets a 29th day whenever the two-digit year is a multiple of four, which is correct up to year 2099. When the year rolls from 99 to 00, a sticky century flag is raised.

Software reaches the clock through a small bytewide register port. It is a pair of plain strobes, not a stream: there is no back-pressure, a write takes effect at the clock edge that samples it, and read data is registered and appears one cycle after the read strobe. Time is never read straight from the live counters. A rising capture bit copies them into holding registers, and that copy waits out any seconds update that is under way. A freeze bit stops the counters so that software can stage a new time in the holding registers. Clearing the freeze bit transfers the staged values into the counters.

A halt bit stops the timebase. A calibration mode brings out a square wave taken from a prescaler bit. A signed correction removes or adds timebase increments once per 64-second window.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00, day-of-week 1, date 01, month 01, year 00. Control (offset 0) and calibration (offset 1) read 0x00, and offsets 9 to 15 always read 0x00. Read data appears on reg_rdata in the cycle after reg_rd.
- R2: Seconds advance once per 2^PRESC_W timebase enables, counted from reset or from the last time load. Seconds and minutes count 00 to 59 in BCD and carry upward. Hours count 00 to 23 in BCD.
- R3: Day-of-week (offset 5, bits 2:0) advances once at each midnight and wraps from 7 to 1.
- R4: The date (offset 6) rolls to 01 after the last day of the month: 31, 30 for months 04/06/09/11, and for month 02 either 29 when the BCD year is divisible by 4 or 28 otherwise. The month (offset 7) then advances, and it rolls from 12 to 01 while the year (offset 8) increments in BCD.
- R5: A year rollover from 99 to 00 sets control bit 7. A read of offset 0 returns the flag and then clears it.
- R6: Setting control bit 0 from 0 to 1 copies the counters into the holding registers read at offsets 2 to 8 (sec, min, hour, dow, date, month, year). While bit 0 stays 1, no further copy happens.
- R7: A capture requested in the same cycle that a seconds update is being applied takes the values after that update.
- R8: While control bit 1 is 1, the counters do not advance and writes to offsets 2 to 8 load the holding registers. Clearing bit 1 copies the holding registers into the counters and restarts the prescaler at zero.
- R9: Writes to offsets 2 to 8 while control bit 1 is 0 have no effect.
- R10: While control bit 3 is 1, timebase enables are ignored.
- R11: While control bit 2 (calibration mode) is 1, sq_out equals prescaler bit SQ_BIT. Otherwise sq_out is 0.
- R12: Calibration register bit 4 (sign) is always writable. Bits MAG_W-1:0 (magnitude) change only on writes made while control bit 2 is 1.
- R13: At the end of every 64th second the magnitude is loaded. During the next second, the first magnitude timebase enables each add 0 to the prescaler when the sign is 1, or add 2 when the sign is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Single-cycle timebase enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| sq_out | output | 1 | Calibration square wave |

## Verification
An error in a BCD digit or a rollover limit stays hidden in the counters until the next capture. It then shows as a wrong byte at the first offset it reaches, so the bench loads a time one tick short of every month boundary in a leap year and in a non-leap year, and reads the result after a single second. A fault in capture or freeze ordering shows as a value that is one second stale or one second early. A fault in the prescaler or the correction shows as a seconds count that is off by one at a pulse count placed exactly on the edge of a second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CAL  = 4'd1;
  localparam logic [3:0] A_SEC  = 4'd2;
  localparam logic [3:0] A_MIN  = 4'd3;
  localparam logic [3:0] A_HOUR = 4'd4;
  localparam logic [3:0] A_DOW  = 4'd5;
  localparam logic [3:0] A_DATE = 4'd6;
  localparam logic [3:0] A_MON  = 4'd7;
  localparam logic [3:0] A_YEAR = 4'd8;

  localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                                     dow: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};

  // one BCD increment of a two-digit value
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
    else                bcd_next = v + 8'd1;
  endfunction

  function automatic logic year_is_leap(input logic [7:0] y);
    int b;
    b = int'(y[7:4]) * 10 + int'(y[3:0]);
    year_is_leap = ((b % 4) == 0);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      month_last = year_is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_last = 6'h30;
      default:                    month_last = 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int PW     = 15,
  parameter int SQ_BIT = 5,
  parameter int MAG_W  = 4,
  parameter int WIN_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             halt,
  input  logic             clr,
  input  logic             cal_mode,
  input  logic             cal_sign,
  input  logic [MAG_W-1:0] cal_mag,
  output logic             tick,
  output logic             sq_out
);

  logic [PW-1:0]    presc;
  logic [MAG_W-1:0] adj;
  logic [WIN_W-1:0] win;
  logic [PW:0]      sum;
  logic [1:0]       step;
  logic             adv, adj_use, wrap;

  always_comb begin
    adv     = tb_en & ~halt;
    adj_use = adv && (adj != '0);
    step    = adj_use ? (cal_sign ? 2'd0 : 2'd2) : 2'd1;
    sum     = {1'b0, presc} + {{(PW-1){1'b0}}, step};
    wrap    = adv & sum[PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      tick  <= 1'b0;
      adj   <= '0;
      win   <= '0;
    end else begin
      if (clr) begin
        presc <= '0;
        tick  <= 1'b0;
      end else begin
        tick <= wrap;
        if (adv) presc <= sum[PW-1:0];
      end
      if (wrap && !clr) begin
        win <= win + 1'b1;
        if (win == '1)   adj <= cal_mag;
        else if (adj_use) adj <= adj - 1'b1;
      end else if (adj_use && !clr) begin
        adj <= adj - 1'b1;
      end
    end
  end

  assign sq_out = cal_mode & presc[SQ_BIT];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr) |=> $stable(presc)); // R10
  AST_REMOVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_use && cal_sign && !clr) |=> $stable(presc)); // R13

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output logic      cy_pulse
);

  rtc_time_t  nxt;
  logic       cy_n;
  logic [7:0] t;

  always_comb begin
    nxt  = cur;
    cy_n = 1'b0;
    t    = bcd_next({1'b0, cur.sec});
    if (cur.sec != 7'h59) nxt.sec = t[6:0];
    else begin
      nxt.sec = '0;
      t = bcd_next({1'b0, cur.min});
      if (cur.min != 7'h59) nxt.min = t[6:0];
      else begin
        nxt.min = '0;
        t = bcd_next({2'b0, cur.hour});
        if (cur.hour != 6'h23) nxt.hour = t[5:0];
        else begin
          nxt.hour = '0;
          nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
          t = bcd_next({2'b0, cur.date});
          if (cur.date != month_last(cur.mon, cur.year)) nxt.date = t[5:0];
          else begin
            nxt.date = 6'h01;
            t = bcd_next({3'b0, cur.mon});
            if (cur.mon != 5'h12) nxt.mon = t[4:0];
            else begin
              nxt.mon = 5'h01;
              if (cur.year != 8'h99) nxt.year = bcd_next(cur.year);
              else begin
                nxt.year = 8'h00;
                cy_n     = 1'b1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= TIME_RST;
      cy_pulse <= 1'b0;
    end else begin
      cy_pulse <= tick & cy_n & ~load;
      if (load)      cur <= load_val;
      else if (tick) cur <= nxt;
    end
  end

  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sec <= 7'h59 && cur.sec[3:0] <= 4'd9)
      |=> (cur.sec <= 7'h59 && cur.sec[3:0] <= 4'd9)); // R2
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.hour <= 6'h23 && cur.hour[3:0] <= 4'd9) |=> (cur.hour <= 6'h23)); // R2
  AST_DOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.dow != 3'd0) |=> (cur.dow != 3'd0)); // R3
  AST_CY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cy_pulse |-> (cur.year == 8'h00 && $past(cur.year) == 8'h99)); // R5

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15,
  parameter int SQ_BIT  = 5,
  parameter int MAG_W   = 4,
  parameter int WIN_W   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sq_out
);

  localparam int PADW = 8 - MAG_W;

  logic             r_q, w_q, calm_q, halt_q, cf_q;
  logic             cal_sign_q;
  logic [MAG_W-1:0] cal_mag_q;
  logic             cap_req, load_q;
  rtc_time_t        hold, cur_time;
  logic             tick_raw, cal_tick, cap_do, cy_pulse;
  logic             wr_ctrl, wr_cal;

  assign cal_tick = tick_raw & ~w_q;
  assign cap_do   = cap_req & ~cal_tick;
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_cal   = reg_wr && (reg_addr == A_CAL);

  rtc_timebase #(.PW(PRESC_W), .SQ_BIT(SQ_BIT), .MAG_W(MAG_W), .WIN_W(WIN_W)) u_tbase (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .halt     (halt_q),
    .clr      (load_q),
    .cal_mode (calm_q),
    .cal_sign (cal_sign_q),
    .cal_mag  (cal_mag_q),
    .tick     (tick_raw),
    .sq_out   (sq_out)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cal_tick),
    .load     (load_q),
    .load_val (hold),
    .cur      (cur_time),
    .cy_pulse (cy_pulse)
  );

  // control, calibration and capture/load sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q        <= 1'b0;
      w_q        <= 1'b0;
      calm_q     <= 1'b0;
      halt_q     <= 1'b0;
      cap_req    <= 1'b0;
      load_q     <= 1'b0;
      cal_sign_q <= 1'b0;
      cal_mag_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (cap_do) cap_req <= 1'b0;
      if (wr_ctrl) begin
        r_q    <= reg_wdata[0];
        w_q    <= reg_wdata[1];
        calm_q <= reg_wdata[2];
        halt_q <= reg_wdata[3];
        if (reg_wdata[0] && !r_q) cap_req <= 1'b1;
        if (!reg_wdata[1] && w_q) load_q  <= 1'b1;
      end
      if (wr_cal) begin
        cal_sign_q <= reg_wdata[4];
        if (calm_q) cal_mag_q <= reg_wdata[MAG_W-1:0];
      end
    end
  end

  // holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= TIME_RST;
    end else if (cap_do) begin
      hold <= cur_time;
    end else if (reg_wr && w_q) begin
      case (reg_addr)
        A_SEC:  hold.sec  <= reg_wdata[6:0];
        A_MIN:  hold.min  <= reg_wdata[6:0];
        A_HOUR: hold.hour <= reg_wdata[5:0];
        A_DOW:  hold.dow  <= reg_wdata[2:0];
        A_DATE: hold.date <= reg_wdata[5:0];
        A_MON:  hold.mon  <= reg_wdata[4:0];
        A_YEAR: hold.year <= reg_wdata;
        default: ;
      endcase
    end
  end

  // century flag and read path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_q      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (cy_pulse) cf_q <= 1'b1;
      else if (reg_rd && reg_addr == A_CTRL) cf_q <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= {cf_q, 3'b000, halt_q, calm_q, w_q, r_q};
          A_CAL:   reg_rdata <= (8'(cal_sign_q) << 4) | {{PADW{1'b0}}, cal_mag_q};
          A_SEC:   reg_rdata <= {1'b0, hold.sec};
          A_MIN:   reg_rdata <= {1'b0, hold.min};
          A_HOUR:  reg_rdata <= {2'b0, hold.hour};
          A_DOW:   reg_rdata <= {5'b0, hold.dow};
          A_DATE:  reg_rdata <= {2'b0, hold.date};
          A_MON:   reg_rdata <= {3'b0, hold.mon};
          A_YEAR:  reg_rdata <= hold.year;
          default: reg_rdata <= 8'h00;
        endcase
      end
    end
  end

  AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_q |=> $stable(cur_time)); // R8
  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_do |=> (hold == $past(cur_time))); // R7
  AST_MAG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !calm_q |=> $stable(cal_mag_q)); // R12
  AST_CF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cy_pulse |=> cf_q); // R5

endmodule

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb_top;

  localparam int PW  = 4;
  localparam int SQ  = 2;
  localparam int SPS = 1 << PW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sq_out;

  int total = 0;
  int bad = 0;
  logic [7:0] base = 8'h00;
  logic [7:0] s, mi, h, dw, dt, mo, yr, v;

  always #2 clk = ~clk;

  rtc_bcd_core #(.PRESC_W(PW), .SQ_BIT(SQ), .MAG_W(4), .WIN_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sq_out(sq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tobcd(input int x);
    return 8'((x / 10) * 16 + (x % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulses(input int n);
    if (n > 0) begin
      @(negedge clk);
      tb_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tb_en = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; base = 8'h00;
    idle(2);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic read_time();
    rd(4'd2, s); rd(4'd3, mi); rd(4'd4, h); rd(4'd5, dw);
    rd(4'd6, dt); rd(4'd7, mo); rd(4'd8, yr);
  endtask

  task automatic capture();
    wr(4'd0, base);
    wr(4'd0, base | 8'h01);
    idle(4);
    read_time();
    wr(4'd0, base);
  endtask

  task automatic set_time(input logic [7:0] ts, tm, th, tw, td, tmo, ty);
    wr(4'd0, base | 8'h02);
    wr(4'd2, ts); wr(4'd3, tm); wr(4'd4, th); wr(4'd5, tw);
    wr(4'd6, td); wr(4'd7, tmo); wr(4'd8, ty);
    wr(4'd0, base);
    idle(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R1 reset state
    read_time();
    chk("R1 sec", s, 8'h00); chk("R1 min", mi, 8'h00); chk("R1 hour", h, 8'h00);
    chk("R1 dow", dw, 8'h01); chk("R1 date", dt, 8'h01); chk("R1 mon", mo, 8'h01);
    chk("R1 year", yr, 8'h00);
    rd(4'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(4'd1, v); chk("R1 cal", v, 8'h00);
    rd(4'd12, v); chk("R1 unmapped", v, 8'h00);

    // R9 time writes ignored without freeze
    wr(4'd2, 8'h33);
    rd(4'd2, v); chk("R9 sec write ignored", v, 8'h00);

    // R7 capture coinciding with the update cycle
    pulses(SPS - 1);
    @(negedge clk);
    tb_en = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    tb_en = 1'b0; reg_wr = 1'b0;
    idle(4);
    rd(4'd2, v); chk("R7 deferred capture", v, 8'h01);

    // R6 no new copy while R stays high
    pulses(SPS);
    idle(3);
    rd(4'd2, v); chk("R6 hold static", v, 8'h01);
    capture();
    chk("R6 fresh capture", s, 8'h02);

    // R2 long run: 1h 2m 5s
    do_reset();
    pulses(SPS * 3725);
    idle(3);
    capture();
    chk("R2 sec", s, 8'h05); chk("R2 min", mi, 8'h02); chk("R2 hour", h, 8'h01);
    chk("R3 dow unchanged", dw, 8'h01);

    // R2 hour digit carry
    set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h05, 8'h20);
    pulses(SPS); idle(3); capture();
    chk("R2 hour carry", h, 8'h10); chk("R2 min wrap", mi, 8'h00); chk("R2 sec wrap", s, 8'h00);
    chk("R3 dow mid", dw, 8'h02);

    // R4 R3 month boundary sweep
    for (int yi = 0; yi < 2; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        automatic int y = (yi == 0) ? 1 : 4;
        automatic int last = mdays(m, y);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, tobcd(last), tobcd(m), tobcd(y));
        pulses(SPS); idle(3); capture();
        chk("R4 date roll", dt, 8'h01);
        chk("R4 month roll", mo, tobcd((m % 12) + 1));
        chk("R4 year", yr, tobcd(y + ((m == 12) ? 1 : 0)));
        chk("R3 dow wrap", dw, 8'h01);
        chk("R2 midnight", h, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, tobcd(last - 1), tobcd(m), tobcd(y));
        pulses(SPS); idle(3); capture();
        chk("R4 last day", dt, tobcd(last));
        chk("R4 month hold", mo, tobcd(m));
        chk("R3 dow step", dw, 8'h04);
      end
    end

    // R5 century rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulses(SPS); idle(3); capture();
    chk("R5 year wrap", yr, 8'h00); chk("R5 month", mo, 8'h01);
    rd(4'd0, v); chk("R5 flag set", v & 8'h80, 8'h80);
    rd(4'd0, v); chk("R5 flag cleared", v & 8'h80, 8'h00);

    // R8 freeze then load
    wr(4'd0, 8'h02);
    wr(4'd2, 8'h41); wr(4'd3, 8'h17); wr(4'd4, 8'h06);
    pulses(SPS * 3); idle(3);
    wr(4'd0, 8'h00); idle(3);
    capture();
    chk("R8 loaded sec", s, 8'h41); chk("R8 loaded min", mi, 8'h17); chk("R8 loaded hour", h, 8'h06);
    pulses(SPS - 1); idle(3); capture();
    chk("R8 prescaler restarted", s, 8'h41);
    pulses(1); idle(3); capture();
    chk("R8 first second", s, 8'h42);

    // R10 halt
    do_reset();
    wr(4'd0, 8'h08);
    pulses(SPS * 3);
    wr(4'd0, 8'h00);
    capture();
    chk("R10 halted", s, 8'h00);
    pulses(SPS); idle(3); capture();
    chk("R10 resumed", s, 8'h01);

    // R11 square wave
    do_reset();
    base = 8'h04;
    wr(4'd0, base);
    for (int k = 1; k <= 20; k++) begin
      pulses(1);
      chk("R11 sq level", {7'b0, sq_out}, {7'b0, 1'(((k % SPS) >> SQ) & 1)});
    end
    base = 8'h00;
    wr(4'd0, base);
    chk("R11 sq off", {7'b0, sq_out}, 8'h00);

    // R12 magnitude lock
    wr(4'd1, 8'h0F);
    rd(4'd1, v); chk("R12 mag locked", v, 8'h00);
    wr(4'd1, 8'h10);
    rd(4'd1, v); chk("R12 sign free", v, 8'h10);
    wr(4'd0, 8'h04);
    wr(4'd1, 8'h1A);
    rd(4'd1, v); chk("R12 mag written", v, 8'h1A);

    // R13 removal: second 65 lasts SPS+3
    do_reset();
    base = 8'h04;
    wr(4'd0, base); wr(4'd1, 8'h13);
    pulses(SPS * 65 + 2); idle(3); capture();
    chk("R13 remove short", s, 8'h04); chk("R13 remove min", mi, 8'h01);
    pulses(1); idle(3); capture();
    chk("R13 remove edge", s, 8'h05);

    // R13 insertion: second 65 lasts SPS-2
    do_reset();
    base = 8'h04;
    wr(4'd0, base); wr(4'd1, 8'h02);
    pulses(SPS * 65 - 3); idle(3); capture();
    chk("R13 add short", s, 8'h04);
    pulses(1); idle(3); capture();
    chk("R13 add edge", s, 8'h05);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule